// File: doc/BRIEF.md
# External Static Memory Controller

This block sits between an on-chip bus master and up to eight asynchronous SRAM-style devices. The master issues one single-word read or write at a time over a valid/ready request port. The controller turns it into an external cycle: one chip select, an output enable or a write enable, a held address and, for writes, driven data. When the cycle ends, a one-cycle response pulse is returned.

The top three bits of the request address select the bank. The remaining bits go out as the in-bank address. Each bank has its own timing inputs: how many clocks to wait before output enable, how long a read lasts, how long write enable is held, and how many idle clocks to insert when a write follows a read to the same bank. Each wait value is a 4-bit count in system clocks by default. A count of zero is treated as one.

Top module: `ext_sram_ctrl`

## Requirements
- R1: The bank is the value of `req_addr[ADDR_W-1 -: 3]`. During an access only `mem_cs_n[bank]` is low (bank code 110 drives line 6, 111 drives line 7). At all other times every chip select is high.
- R2: A read access holds chip select low for `max(rd_wait,1)` consecutive cycles. Without turnaround, the first of these is the cycle after the request is accepted.
- R3: During a read, `mem_oe_n` goes low at access cycle index `oe_dly` (cycle 0 is the first chip-select cycle) and stays low to the last cycle. Example: delay 3 with read wait 7 gives four cycles of output enable.
- R4: If `oe_dly >= max(rd_wait,1)`, output enable is asserted only on the final read cycle, so it is never absent.
- R5: A write access holds `mem_we_n` low for `max(wr_wait,1)` cycles from the first chip-select cycle. Chip select stays low one more cycle after write enable rises. `mem_wdata_oe` is high and `mem_wdata` equals the request data for the whole write access. Output enable and write enable are never low together.
- R6: `rsp_valid` is high for exactly one cycle, the cycle after the last chip-select cycle. For reads, `rsp_rdata` holds the value of `mem_rdata` sampled in the last access cycle.
- R7: A write that follows a read to the same bank is preceded by `idle` cycles with all chip selects high. An idle count of zero inserts none.
- R8: No turnaround cycles are inserted between accesses to different banks, between two reads, or between two writes.
- R9: `mem_addr` equals the in-bank offset of the request and is stable on every cycle of the access. `req_ready` is low from acceptance until the response cycle.
- R10: After reset every chip select, `mem_oe_n` and `mem_we_n` are high, `mem_wdata_oe` and `rsp_valid` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle; request accepted when both are high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Bank in top 3 bits, offset below |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_valid on reads |
| cfg_oe_dly | input | 8*CNT_W | Per-bank output-enable delay, bank b at [b*CNT_W +: CNT_W] |
| cfg_rd_wait | input | 8*CNT_W | Per-bank read length |
| cfg_wr_wait | input | 8*CNT_W | Per-bank write-enable length |
| cfg_idle | input | 8*CNT_W | Per-bank read-to-write turnaround count |
| mem_cs_n | output | 8 | Active-low chip selects, one per bank |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_addr | output | ADDR_W-3 | In-bank address |
| mem_wdata | output | DATA_W | Write data to the device |
| mem_wdata_oe | output | 1 | Data bus drive enable |
| mem_rdata | input | DATA_W | Read data from the device |

## Verification
The embedded assertions check, on every cycle, the properties that hold at any instant. At most one chip select is low. Output and write enable never overlap. Write enable always rises while chip select is still low. Output enable is present on the last read cycle. The response is a single-cycle pulse. The address holds through an access. Turnaround occurs only after a read to the same bank. The exact cycle counts can be shown only by the bench's directed scenarios: chip-select length, output-enable start, write-enable width, turnaround length, the clamp boundary, and the returned data.

// File: rtl/sram_ctrl_pkg.sv
// Shared definitions for the external static memory controller.
// Assumes the bank field is always three bits wide (eight banks).
package sram_ctrl_pkg;
    localparam int BANK_W = 3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_TURN = 2'd1,
        ST_ACC  = 2'd2
    } esmc_state_e;
endpackage

// File: rtl/sram_bank_cfg_mux.sv
// Selects one bank's timing configuration and normalises it.
// Zero wait counts become one; the output-enable delay is clamped so that
// output enable covers at least the final read cycle.
// Assumes configuration inputs are quasi-static.
module sram_bank_cfg_mux #(
    parameter int NBANK  = 8,
    parameter int CNT_W  = 4,
    parameter int BANK_W = 3
) (
    input  logic [BANK_W-1:0]      bank_idx,
    input  logic [NBANK*CNT_W-1:0] cfg_oe_dly,
    input  logic [NBANK*CNT_W-1:0] cfg_rd_wait,
    input  logic [NBANK*CNT_W-1:0] cfg_wr_wait,
    input  logic [NBANK*CNT_W-1:0] cfg_idle,
    output logic [CNT_W-1:0]       oe_eff,
    output logic [CNT_W-1:0]       rd_len,
    output logic [CNT_W-1:0]       wr_len,
    output logic [CNT_W-1:0]       idle_n
);
    logic [CNT_W-1:0] oe_a   [NBANK];
    logic [CNT_W-1:0] rd_a   [NBANK];
    logic [CNT_W-1:0] wr_a   [NBANK];
    logic [CNT_W-1:0] idle_a [NBANK];
    logic [CNT_W-1:0] oe_sel, rd_sel, wr_sel;

    for (genvar g = 0; g < NBANK; g++) begin : g_unpack
        assign oe_a[g]   = cfg_oe_dly[g*CNT_W +: CNT_W];
        assign rd_a[g]   = cfg_rd_wait[g*CNT_W +: CNT_W];
        assign wr_a[g]   = cfg_wr_wait[g*CNT_W +: CNT_W];
        assign idle_a[g] = cfg_idle[g*CNT_W +: CNT_W];
    end

    // Pick the addressed bank and apply the minimum/clamp rules.
    always_comb begin
        oe_sel = oe_a[bank_idx];
        rd_sel = rd_a[bank_idx];
        wr_sel = wr_a[bank_idx];
        idle_n = idle_a[bank_idx];
        rd_len = (rd_sel == '0) ? CNT_W'(1) : rd_sel;
        wr_len = (wr_sel == '0) ? CNT_W'(1) : wr_sel;
        oe_eff = (oe_sel >= rd_len) ? rd_len - CNT_W'(1) : oe_sel;
    end
endmodule

// File: rtl/sram_cycle_fsm.sv
// Sequences one external access: optional turnaround, then the chip-select
// window with output-enable or write-enable timing, then a response pulse.
// Assumes timing values arrive already normalised by sram_bank_cfg_mux.
module sram_cycle_fsm
    import sram_ctrl_pkg::*;
#(
    parameter int OFFS_W = 21,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [OFFS_W-1:0] req_offs,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    input  logic [CNT_W-1:0]  oe_eff,
    input  logic [CNT_W-1:0]  rd_len,
    input  logic [CNT_W-1:0]  wr_len,
    input  logic [CNT_W-1:0]  idle_n,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              acc_active,
    output logic [BANK_W-1:0] acc_bank,
    output logic              oe_act,
    output logic              we_act,
    output logic              wdata_oe,
    output logic [OFFS_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);
    localparam int CW1 = CNT_W + 1;

    esmc_state_e      state;
    logic [CW1-1:0]   cnt;
    logic             wr_q;
    logic [CNT_W-1:0] oe_q, rl_q, wl_q;
    logic             last_rd;
    logic [BANK_W-1:0] last_bank;
    logic [CW1-1:0]   acc_len;
    logic             acc_last;
    logic             need_turn;

    // Access length and end-of-access detection.
    always_comb begin
        acc_len  = wr_q ? ({1'b0, wl_q} + CW1'(1)) : {1'b0, rl_q};
        acc_last = (cnt == acc_len - CW1'(1));
        need_turn = req_write && last_rd && (last_bank == req_bank) && (idle_n != '0);
    end

    // Strobe decode from the sequencer state.
    always_comb begin
        acc_active = (state == ST_ACC);
        req_ready  = (state == ST_IDLE);
        oe_act     = acc_active && !wr_q && (cnt >= {1'b0, oe_q});
        we_act     = acc_active && wr_q && (cnt < {1'b0, wl_q});
        wdata_oe   = acc_active && wr_q;
    end

    assign acc_bank = last_bank_or_cur();

    function automatic logic [BANK_W-1:0] last_bank_or_cur();
        return cur_bank;
    endfunction

    logic [BANK_W-1:0] cur_bank;

    // Main sequencer: latch request, count turnaround and access cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            wr_q      <= 1'b0;
            cur_bank  <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            oe_q      <= '0;
            rl_q      <= '0;
            wl_q      <= '0;
            last_rd   <= 1'b0;
            last_bank <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        wr_q     <= req_write;
                        cur_bank <= req_bank;
                        addr_q   <= req_offs;
                        wdata_q  <= req_wdata;
                        oe_q     <= oe_eff;
                        rl_q     <= rd_len;
                        wl_q     <= wr_len;
                        if (need_turn) begin
                            state <= ST_TURN;
                            cnt   <= {1'b0, idle_n} - CW1'(1);
                        end else begin
                            state <= ST_ACC;
                            cnt   <= '0;
                        end
                    end
                end
                ST_TURN: begin
                    if (cnt == '0) state <= ST_ACC;
                    else           cnt   <= cnt - CW1'(1);
                end
                ST_ACC: begin
                    if (acc_last) begin
                        state     <= ST_IDLE;
                        cnt       <= '0;
                        rsp_valid <= 1'b1;
                        if (!wr_q) rsp_rdata <= mem_rdata;
                        last_rd   <= !wr_q;
                        last_bank <= cur_bank;
                    end else begin
                        cnt <= cnt + CW1'(1);
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: read and write strobes never overlap.
    p_oe_we_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(oe_act && we_act));

    // R5: write enable rises while chip select is still asserted.
    p_we_inside_cs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(we_act) |-> acc_active);

    // R4: output enable is present on the last read cycle.
    p_oe_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_active && !wr_q && acc_last) |-> oe_act);

    // R6: the response is a single-cycle pulse.
    p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R9: the address is held across the access.
    p_addr_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_active && $past(acc_active)) |-> $stable(addr_q));

    // R7: turnaround only for a write after a read to the same bank.
    p_turn_same_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_TURN) |-> (wr_q && last_rd && (last_bank == cur_bank)));
endmodule

// File: rtl/ext_sram_ctrl.sv
// External static memory controller top: decodes the bank from the upper
// address bits, selects that bank's timing, and sequences one SRAM-style
// access per request. Assumes one outstanding request at a time.
module ext_sram_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter  int ADDR_W = 24,
    parameter  int DATA_W = 32,
    parameter  int CNT_W  = 4,
    localparam int NBANK  = 1 << BANK_W,
    localparam int OFFS_W = ADDR_W - BANK_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [DATA_W-1:0]      rsp_rdata,
    input  logic [NBANK*CNT_W-1:0] cfg_oe_dly,
    input  logic [NBANK*CNT_W-1:0] cfg_rd_wait,
    input  logic [NBANK*CNT_W-1:0] cfg_wr_wait,
    input  logic [NBANK*CNT_W-1:0] cfg_idle,
    output logic [NBANK-1:0]       mem_cs_n,
    output logic                   mem_oe_n,
    output logic                   mem_we_n,
    output logic [OFFS_W-1:0]      mem_addr,
    output logic [DATA_W-1:0]      mem_wdata,
    output logic                   mem_wdata_oe,
    input  logic [DATA_W-1:0]      mem_rdata
);
    logic [BANK_W-1:0] req_bank;
    logic [CNT_W-1:0]  oe_eff, rd_len, wr_len, idle_n;
    logic              acc_active, oe_act, we_act;
    logic [BANK_W-1:0] acc_bank;

    assign req_bank = req_addr[ADDR_W-1 -: BANK_W];

    sram_bank_cfg_mux #(
        .NBANK(NBANK), .CNT_W(CNT_W), .BANK_W(BANK_W)
    ) i_cfg (
        .bank_idx   (req_bank),
        .cfg_oe_dly (cfg_oe_dly),
        .cfg_rd_wait(cfg_rd_wait),
        .cfg_wr_wait(cfg_wr_wait),
        .cfg_idle   (cfg_idle),
        .oe_eff     (oe_eff),
        .rd_len     (rd_len),
        .wr_len     (wr_len),
        .idle_n     (idle_n)
    );

    sram_cycle_fsm #(
        .OFFS_W(OFFS_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
    ) i_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_bank  (req_bank),
        .req_offs  (req_addr[OFFS_W-1:0]),
        .req_wdata (req_wdata),
        .req_ready (req_ready),
        .oe_eff    (oe_eff),
        .rd_len    (rd_len),
        .wr_len    (wr_len),
        .idle_n    (idle_n),
        .mem_rdata (mem_rdata),
        .acc_active(acc_active),
        .acc_bank  (acc_bank),
        .oe_act    (oe_act),
        .we_act    (we_act),
        .wdata_oe  (mem_wdata_oe),
        .addr_q    (mem_addr),
        .wdata_q   (mem_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    // One active-low chip select per bank, low only during its access.
    for (genvar g = 0; g < NBANK; g++) begin : g_cs
        assign mem_cs_n[g] = !(acc_active && (acc_bank == BANK_W'(g)));
    end

    assign mem_oe_n = !oe_act;
    assign mem_we_n = !we_act;

    // R1: at most one chip select is low at any time.
    p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~mem_cs_n));
endmodule

// File: tb/test_ext_sram_ctrl.sv
// Directed bench for ext_sram_ctrl: one task per scenario.
module test_ext_sram_ctrl;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 4;
    localparam int NB     = 8;
    localparam int OFFS_W = 21;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [NB*CNT_W-1:0] cfg_oe_dly, cfg_rd_wait, cfg_wr_wait, cfg_idle;
    logic [NB-1:0] mem_cs_n;
    logic mem_oe_n, mem_we_n, mem_wdata_oe;
    logic [OFFS_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;

    int oe_c [NB] = '{0, 1, 3, 2, 1, 9, 2, 1};
    int rd_c [NB] = '{0, 3, 7, 5, 2, 4, 4, 3};
    int wr_c [NB] = '{0, 2, 4, 3, 2, 3, 3, 2};
    int id_c [NB] = '{2, 1, 2, 2, 2, 1, 3, 0};

    always #2 clk = ~clk;  // 250 MHz

    assign mem_rdata = {11'h5A5, mem_addr};

    always_comb begin
        for (int b = 0; b < NB; b++) begin
            cfg_oe_dly[b*CNT_W +: CNT_W]  = CNT_W'(oe_c[b]);
            cfg_rd_wait[b*CNT_W +: CNT_W] = CNT_W'(rd_c[b]);
            cfg_wr_wait[b*CNT_W +: CNT_W] = CNT_W'(wr_c[b]);
            cfg_idle[b*CNT_W +: CNT_W]    = CNT_W'(id_c[b]);
        end
    end

    ext_sram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) i_ext_sram_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .cfg_oe_dly(cfg_oe_dly), .cfg_rd_wait(cfg_rd_wait),
        .cfg_wr_wait(cfg_wr_wait), .cfg_idle(cfg_idle),
        .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wdata_oe(mem_wdata_oe),
        .mem_rdata(mem_rdata)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Issue one access and measure every strobe cycle by cycle.
    task automatic run_access(input bit wr, input int bank, input int off,
                              input int wd, input int exp_gap, input string tag);
        int gap = 0, cs_len = 0, oe_first = -1, oe_len = 0, we_len = 0;
        int bad_bank = 0, addr_bad = 0, wd_bad = 0, rdy_bad = 0;
        bit seen = 1'b0;
        logic [DATA_W-1:0] got = '0;
        int rl, wl, cs_exp, oef;
        logic [NB-1:0] cs_exp_v;
        rl = (rd_c[bank] == 0) ? 1 : rd_c[bank];
        wl = (wr_c[bank] == 0) ? 1 : wr_c[bank];
        cs_exp = wr ? wl + 1 : rl;
        oef = (oe_c[bank] >= rl) ? rl - 1 : oe_c[bank];
        cs_exp_v = ~(NB'(1) << bank);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {3'(bank), 21'(off)};
        req_wdata = wd;
        @(posedge clk);
        for (int i = 0; i < 64 && !seen; i++) begin
            @(negedge clk);
            req_valid = 1'b0;
            if (rsp_valid) begin
                seen = 1'b1;
                got = rsp_rdata;
            end else begin
                if (mem_cs_n == '1) begin
                    if (cs_len == 0) gap++;
                end else begin
                    if (mem_cs_n != cs_exp_v) bad_bank++;
                    if (mem_addr != OFFS_W'(off)) addr_bad++;
                    if (!mem_oe_n) begin
                        if (oe_first < 0) oe_first = cs_len;
                        oe_len++;
                    end
                    if (!mem_we_n) we_len++;
                    if (wr && (mem_wdata != DATA_W'(wd) || !mem_wdata_oe)) wd_bad++;
                    cs_len++;
                end
                if (req_ready) rdy_bad++;
            end
        end
        chk(seen, {tag, " R6 response seen"}, seen, 1);
        chk(bad_bank == 0, {tag, " R1 chip-select line"}, bad_bank, 0);
        chk(addr_bad == 0, {tag, " R9 address"}, addr_bad, 0);
        chk(rdy_bad == 0, {tag, " R9 ready low"}, rdy_bad, 0);
        chk(gap == exp_gap, {tag, " R7/R8 gap"}, gap, exp_gap);
        if (wr) begin
            chk(cs_len == cs_exp, {tag, " R5 cs length"}, cs_len, cs_exp);
            chk(we_len == wl, {tag, " R5 we length"}, we_len, wl);
            chk(oe_len == 0, {tag, " R5 no oe"}, oe_len, 0);
            chk(wd_bad == 0, {tag, " R5 wdata"}, wd_bad, 0);
        end else begin
            chk(cs_len == cs_exp, {tag, " R2 cs length"}, cs_len, cs_exp);
            chk(oe_first == oef, {tag, " R3/R4 oe start"}, oe_first, oef);
            chk(oe_len == rl - oef, {tag, " R3/R4 oe length"}, oe_len, rl - oef);
            chk(we_len == 0, {tag, " R3 no we"}, we_len, 0);
            chk(got == {11'h5A5, 21'(off)}, {tag, " R6 rdata"}, got, {11'h5A5, 21'(off)});
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(mem_cs_n == '1, "R10 cs high", mem_cs_n, 255);
        chk(mem_oe_n && mem_we_n, "R10 oe/we high", {mem_oe_n, mem_we_n}, 3);
        chk(!rsp_valid && !mem_wdata_oe, "R10 rsp/wdata_oe low", {rsp_valid, mem_wdata_oe}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R10 ready", req_ready, 1);
        chk(mem_cs_n == '1, "R10 cs idle", mem_cs_n, 255);
    endtask

    task automatic t_read_example();   // R2, R3: delay 3, wait 7
        run_access(1'b0, 2, 21'h012345, 0, 0, "rd_bank2");
    endtask

    task automatic t_clamp_oe();       // R4: delay 9 > wait 4
        run_access(1'b0, 5, 21'h1ABCDE, 0, 0, "clamp_bank5");
    endtask

    task automatic t_min_wait();       // R2, R5, R7 with zero waits
        run_access(1'b0, 0, 21'h000011, 0, 0, "min_rd_bank0");
        run_access(1'b1, 0, 21'h000022, 32'hCAFE0001, 2, "min_wr_bank0");
    endtask

    task automatic t_write();          // R5, R8 write after write
        run_access(1'b1, 3, 21'h0F0F0F, 32'h12345678, 0, "wr_bank3");
    endtask

    task automatic t_turnaround();     // R7
        run_access(1'b0, 6, 21'h000100, 0, 0, "ta_rd_bank6");
        run_access(1'b1, 6, 21'h000104, 32'hDEADBEEF, 3, "ta_wr_bank6");
    endtask

    task automatic t_diff_bank();      // R8 different bank
        run_access(1'b0, 6, 21'h000200, 0, 0, "db_rd_bank6");
        run_access(1'b1, 4, 21'h000204, 32'h0BADF00D, 0, "db_wr_bank4");
    endtask

    task automatic t_read_read();      // R8 read after read
        run_access(1'b0, 1, 21'h000300, 0, 0, "rr_rd1_bank1");
        run_access(1'b0, 1, 21'h000304, 0, 0, "rr_rd2_bank1");
    endtask

    task automatic t_zero_idle();      // R7 zero idle count
        run_access(1'b0, 7, 21'h000400, 0, 0, "zi_rd_bank7");
        run_access(1'b1, 7, 21'h000404, 32'h00C0FFEE, 0, "zi_wr_bank7");
    endtask

    task automatic t_all_banks();      // R1 decode of every bank code
        for (int b = 0; b < NB; b++)
            run_access(1'b0, b, 21'h100000 + b, 0, 0, "R1_sweep");
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_read_example();
        t_clamp_oe();
        t_min_wait();
        t_write();
        t_turnaround();
        t_diff_bank();
        t_read_read();
        t_zero_idle();
        t_all_banks();
        repeat (4) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule